// File: doc/BRIEF.md
# Vector Loop State Register

This block holds the architectural state that steers a vector loop. The state covers the largest allowed vector length, the current vector length, the element positions reached on the source and destination sides, the sub-element positions on each side, and the sub-vector group size. It also holds a set of mode bits: a vertical-first flag, a remap-keep flag, pack and unpack ordering flags, a parallelism hint, five remap enables and a two-bit shape selector for each enable.

A set-length operation loads the maximum from an immediate operand and sets the vector length to whichever is smaller, the requested count or that maximum. A whole-register write port loads every field in one cycle. A combinational read port returns every field. Together these two ports serve context save and restore. A write or set-length operation that would put a reserved value into the register raises an illegal-operation flag in the same cycle and leaves the register untouched.

Top module: `vlstate_reg`

## Requirements
- R1: After reset, `rd_data` is all zeros, `illegal_op` is low and `group_size` is 1.
- R2: An accepted set-length operation loads the maximum field with `set_max_imm` and the length field with min(`set_req_len`, `set_max_imm`). The result is visible on `rd_data` after the next rising clock edge.
- R3: A legal write of `wr_data` is visible on `rd_data` after the next edge. The word layout is: bits 6:0 maximum, 13:7 length, 20:14 source position, 27:21 destination position, 29:28 source sub-position, 31:30 destination sub-position, 33:32 group code, 34 vertical-first, 35 remap-keep, 36 pack, 37 unpack, 44:38 hint, 49:45 remap enables, 59:50 shape selectors (two bits per enable). Bits 63:60 are ignored on write and read back as zero.
- R4: A write whose source or destination position is 64 or more drives `illegal_op` high in that cycle and leaves the register unchanged. A position of 63 is legal.
- R5: A write whose length or maximum is above 64 drives `illegal_op` high and leaves the register unchanged. A value of exactly 64 in both fields is legal.
- R6: A set-length operation with `set_max_imm` above 64 drives `illegal_op` high and leaves the register unchanged.
- R7: An accepted set-length operation clears the remap-keep bit (bit 35) when it changes the length or the maximum. It leaves that bit as it was when both fields keep their values.
- R8: When `wr_en` and `set_en` are high in the same cycle, only the write is considered. The set-length request is ignored, and it is ignored even when the write traps.
- R9: `group_size` equals the group code (bits 33:32) plus one, giving 1 to 4.
- R10: A set-length operation leaves every field other than the length, the maximum and the remap-keep bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Whole-register write strobe |
| wr_data | input | 64 | Word to load on write |
| set_en | input | 1 | Set-length strobe |
| set_req_len | input | REQ_W (16) | Requested element count |
| set_max_imm | input | 7 | Immediate maximum for set-length |
| rd_data | output | 64 | Current register contents |
| group_size | output | 3 | Sub-vector group size, 1 to 4 |
| illegal_op | output | 1 | Reserved value offered this cycle |

## Verification
Any wrong internal value appears on `rd_data` right after the clock edge that produced it, because the read port carries the stored register directly with no further logic. A trapping request that corrupts state therefore shows up one cycle after the trap. A lost remap-keep bit after an unchanged set-length also shows one cycle later. A wrong trap decision appears on `illegal_op` in the same cycle as the request, before any clock edge. The bench therefore checks the flag during the request cycle and checks the full word one cycle later.

// File: rtl/vlstate_reg.sv
module vlstate_reg #(
  parameter int REQ_W      = 16,
  parameter int LEN_W      = 7,
  parameter int STEP_LIMIT = 64,
  parameter int LEN_LIMIT  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic             set_en,
  input  logic [REQ_W-1:0] set_req_len,
  input  logic [LEN_W-1:0] set_max_imm,
  output logic [63:0]      rd_data,
  output logic [2:0]       group_size,
  output logic             illegal_op
);
  localparam int WORD_W  = 64;
  localparam int MAX_LO  = 0;
  localparam int LEN_LO  = MAX_LO + LEN_W;
  localparam int SRC_LO  = LEN_LO + LEN_W;
  localparam int DST_LO  = SRC_LO + LEN_W;
  localparam int SSUB_LO = DST_LO + LEN_W;
  localparam int DSUB_LO = SSUB_LO + 2;
  localparam int GRP_LO  = DSUB_LO + 2;
  localparam int KEEP_B  = GRP_LO + 3;
  localparam int STATE_W = 60;
  localparam int PAD_W   = WORD_W - STATE_W;

  logic [STATE_W-1:0] st;

  logic [LEN_W-1:0] max_q, len_q, src_q, dst_q;
  logic [LEN_W-1:0] w_max, w_len, w_src, w_dst;
  logic [LEN_W-1:0] new_len;
  logic             wr_bad, set_bad, set_ok, wr_ok;

  assign max_q = st[MAX_LO +: LEN_W];
  assign len_q = st[LEN_LO +: LEN_W];
  assign src_q = st[SRC_LO +: LEN_W];
  assign dst_q = st[DST_LO +: LEN_W];

  assign w_max = wr_data[MAX_LO +: LEN_W];
  assign w_len = wr_data[LEN_LO +: LEN_W];
  assign w_src = wr_data[SRC_LO +: LEN_W];
  assign w_dst = wr_data[DST_LO +: LEN_W];

  assign wr_bad = (int'(w_max) > LEN_LIMIT) || (int'(w_len) > LEN_LIMIT) ||
                  (int'(w_src) >= STEP_LIMIT) || (int'(w_dst) >= STEP_LIMIT);
  assign set_bad = int'(set_max_imm) > LEN_LIMIT;

  assign new_len = (set_req_len < REQ_W'(set_max_imm)) ? set_req_len[LEN_W-1:0] : set_max_imm;

  assign wr_ok  = wr_en && !wr_bad;
  assign set_ok = !wr_en && set_en && !set_bad;

  assign illegal_op = wr_en ? wr_bad : (set_en && set_bad);
  assign rd_data    = {{PAD_W{1'b0}}, st};
  assign group_size = {1'b0, st[GRP_LO +: 2]} + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (wr_ok) begin
      st <= wr_data[STATE_W-1:0];
    end else if (set_ok) begin
      st[MAX_LO +: LEN_W] <= set_max_imm;
      st[LEN_LO +: LEN_W] <= new_len;
      if (new_len != len_q || set_max_imm != max_q) st[KEEP_B] <= 1'b0;
    end
  end

  AST_TRAP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> $stable(st)); // R4
  AST_SET_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> (len_q <= max_q)); // R2
  AST_KEEP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok && (new_len != len_q || set_max_imm != max_q)) |=> !st[KEEP_B]); // R7
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_q) < STEP_LIMIT) && (int'(dst_q) < STEP_LIMIT)); // R4
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_q) <= LEN_LIMIT) && (int'(max_q) <= LEN_LIMIT)); // R5
  AST_SET_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> (st[STATE_W-1:KEEP_B+1] == $past(st[STATE_W-1:KEEP_B+1]))); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0)); // R1
endmodule

// File: tb/sim_vlstate_reg.sv
module sim_vlstate_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        set_en = 1'b0;
  logic [15:0] set_req_len = '0;
  logic [6:0]  set_max_imm = '0;
  logic [63:0] rd_data;
  logic [2:0]  group_size;
  logic        illegal_op;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic ill_seen;
  logic [63:0] model;

  always #5 clk = ~clk;

  vlstate_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .set_en(set_en), .set_req_len(set_req_len), .set_max_imm(set_max_imm),
    .rd_data(rd_data), .group_size(group_size), .illegal_op(illegal_op)
  );

  function automatic logic [63:0] mk(int mx, int ln, int sp, int dp, int ss, int ds,
                                     int grp, int vf, int kp, int pk, int up,
                                     int hint, int en, int sel);
    logic [63:0] w = '0;
    w[6:0] = 7'(mx);   w[13:7] = 7'(ln);  w[20:14] = 7'(sp); w[27:21] = 7'(dp);
    w[29:28] = 2'(ss); w[31:30] = 2'(ds); w[33:32] = 2'(grp);
    w[34] = 1'(vf); w[35] = 1'(kp); w[36] = 1'(pk); w[37] = 1'(up);
    w[44:38] = 7'(hint); w[49:45] = 5'(en); w[59:50] = 10'(sel);
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(bit w, logic [63:0] wd, bit s, int req, int imm);
    wr_en = w; wr_data = wd; set_en = s;
    set_req_len = 16'(req); set_max_imm = 7'(imm);
    #1 ill_seen = illegal_op;
    @(negedge clk);
    wr_en = 1'b0; set_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data, 64'd0);
    chk("R1 ill", {63'd0, illegal_op}, 64'd0);
    chk("R1 grp", {61'd0, group_size}, 64'd1);
  endtask

  task automatic t_write_read;
    logic [63:0] a = mk(40, 33, 12, 63, 1, 2, 3, 1, 1, 0, 1, 77, 5'b10110, 10'h2B5);
    cyc(1, a, 0, 0, 0);
    chk("R3 ill", {63'd0, ill_seen}, 64'd0);
    chk("R3 rd", rd_data, a);
    chk("R9 grp4", {61'd0, group_size}, 64'd4);
    cyc(1, a | 64'hF000_0000_0000_0000, 0, 0, 0);
    chk("R3 pad", rd_data, a);
    a = mk(64, 64, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    cyc(1, a, 0, 0, 0);
    chk("R5 64ok ill", {63'd0, ill_seen}, 64'd0);
    chk("R5 64ok rd", rd_data, a);
    chk("R9 grp2", {61'd0, group_size}, 64'd2);
    model = a;
  endtask

  task automatic t_step_trap;
    cyc(1, mk(10, 5, 64, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0);
    chk("R4 src64 ill", {63'd0, ill_seen}, 64'd1);
    chk("R4 src64 rd", rd_data, model);
    cyc(1, mk(10, 5, 0, 100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0);
    chk("R4 dst100 ill", {63'd0, ill_seen}, 64'd1);
    chk("R4 dst100 rd", rd_data, model);
  endtask

  task automatic t_len_trap;
    cyc(1, mk(64, 65, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0);
    chk("R5 len65 ill", {63'd0, ill_seen}, 64'd1);
    chk("R5 len65 rd", rd_data, model);
    cyc(1, mk(127, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0);
    chk("R5 max127 ill", {63'd0, ill_seen}, 64'd1);
    chk("R5 max127 rd", rd_data, model);
  endtask

  task automatic t_setlen;
    logic [63:0] a = mk(20, 10, 7, 9, 2, 1, 2, 1, 1, 1, 1, 33, 5'b11111, 10'h3C3);
    cyc(1, a, 0, 0, 0);
    cyc(0, '0, 1, 10, 20);
    chk("R7 keep held", rd_data, a);
    cyc(0, '0, 1, 300, 64);
    a[6:0] = 7'd64; a[13:7] = 7'd64; a[35] = 1'b0;
    chk("R2 R7 R10 clamp", rd_data, a);
    a[35] = 1'b1;
    cyc(1, a, 0, 0, 0);
    cyc(0, '0, 1, 5, 50);
    a[6:0] = 7'd50; a[13:7] = 7'd5; a[35] = 1'b0;
    chk("R2 R10 req<max", rd_data, a);
    cyc(0, '0, 1, 9, 0);
    a[6:0] = 7'd0; a[13:7] = 7'd0;
    chk("R2 zero max", rd_data, a);
    cyc(0, '0, 1, 3, 65);
    chk("R6 ill", {63'd0, ill_seen}, 64'd1);
    chk("R6 rd", rd_data, a);
    model = a;
  endtask

  task automatic t_priority;
    logic [63:0] b = mk(30, 30, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(1, b, 1, 4, 8);
    chk("R8 write wins", rd_data, b);
    cyc(1, mk(30, 99, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 1, 4, 8);
    chk("R8 trap ill", {63'd0, ill_seen}, 64'd1);
    chk("R8 trap set ignored", rd_data, b);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_step_trap();
    t_len_trap();
    t_setlen();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule